// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-event flags and the per-source enable bits that sit beside a 16-bit timer, and turns them into one interrupt request line per source. It watches the counter value against three compare values, an overflow event, a capture event, and a "capture register is TOP" condition, and it raises the matching flag. The counter, waveform generation and output pins belong to neighbouring logic.

Software reaches the block through a small register bus with two registers: the flag register, where bus_addr is 0, and the enable register, where bus_addr is 1. A one in a flag bit of a write clears that flag. The interrupt controller pulses a one-hot acknowledge when it services a vector, and that pulse clears the matching flag. Compare flags appear one timer tick after the match. Forced-compare strobes never raise a flag.

Top module: `tifc_top`

## Requirements
- R1: After reset, both registers read zero and every irq output is low.
- R2: The flag register uses these bits: 0 overflow, 1 compare A, 2 compare B, 3 compare C, 5 capture. Bits 7, 6 and 4 always read zero, and writes to them have no effect.
- R3: The enable register is read/write and uses the same bit positions as the flag register. Bits 7, 6 and 4 read zero.
- R4: Each irq bit is high exactly when its flag, its enable bit and gie are all high. The irq order is 0 overflow, 1 compare A, 2 compare B, 3 compare C, 4 capture.
- R5: A compare match is sampled on a cycle with tick high. The matching flag rises after the next cycle with tick high, and not earlier.
- R6: The force_cmp strobes (bit 0 A, bit 1 B, bit 2 C) never set a compare flag.
- R7: ovf_evt sets the overflow flag only on a cycle with tick high.
- R8: cap_evt sets the capture flag on any cycle. When top_is_cap is high, a cycle with tick high and count equal to cap_top also sets it.
- R9: A flag-register write clears every flag whose bit is one. Flags whose bit is zero keep their value.
- R10: An ack pulse clears the matching flag. ack uses the irq bit order and is one-hot or zero.
- R11: When a set event and a clear by write or ack fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| count | input | CNT_W | Counter value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| cmp_c | input | CNT_W | Compare value C |
| cap_top | input | CNT_W | Capture register value, used as TOP |
| top_is_cap | input | 1 | Capture register selected as TOP |
| ovf_evt | input | 1 | Counter overflow event |
| cap_evt | input | 1 | Input capture event |
| force_cmp | input | 3 | Forced compare strobes, bit 0 A, bit 1 B, bit 2 C |
| gie | input | 1 | Global interrupt enable |
| ack | input | 5 | One-hot vector acknowledge |
| bus_addr | input | 1 | 0 selects the flag register, 1 selects the enable register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 5 | Interrupt requests |

## Verification
The bench builds the block with CNT_W set to 4. With so few counter values, compare hits and TOP hits happen often while the stimulus is random, so they regularly meet ticks, clears and acknowledges in the same cycle. The narrow width also lets the directed cases pick exact counter values, which places a match on a chosen cycle. It can then show that nothing happens while tick stays low between the match and the flag.

// File: rtl/tifc_pkg.sv
package tifc_pkg;
    localparam int NSRC   = 5;
    localparam int NCMP   = 3;
    localparam int REG_W  = 8;
    localparam int SRC_OVF  = 0;
    localparam int SRC_CMPA = 1;
    localparam int SRC_CAP  = 4;
    localparam logic [REG_W-1:0] REG_MASK = 8'h2F;

    // register bit used by each interrupt source
    function automatic int src_bit(input int src);
        return (src == SRC_CAP) ? 5 : src;
    endfunction
endpackage

// File: rtl/tifc_event_gen.sv
module tifc_event_gen
    import tifc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [CNT_W-1:0]           count_i,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0]           cap_top_i,
    input  logic                       top_is_cap_i,
    input  logic                       ovf_i,
    input  logic                       cap_i,
    output logic [NSRC-1:0]            set_o
);
    typedef struct packed {
        logic [NCMP-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        set_o = '0;
        if (tick_i) begin
            for (int c = 0; c < NCMP; c++) begin
                set_o[SRC_CMPA+c] = st_q.pend[c];
                st_d.pend[c]      = (count_i == cmp_i[c]);
            end
            set_o[SRC_OVF] = ovf_i;
        end
        set_o[SRC_CAP] = cap_i | (tick_i & top_is_cap_i & (count_i == cap_top_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_OVF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        set_o[SRC_OVF] |-> tick_i && ovf_i); // R7
endmodule

// File: rtl/tifc_flag_bank.sv
module tifc_flag_bank
    import tifc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] ack_i,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] en_o
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
        logic [NSRC-1:0] en;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~(clr_i | ack_i)) | set_i;
        if (en_wr_i) st_d.en = en_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_i)); // R10

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]); // R11
        AST_WR1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] && !set_i[i] |=> !flags_o[i]); // R9
        AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            ack_i[i] && !set_i[i] |=> !flags_o[i]); // R10
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            flags_o[i] && !clr_i[i] && !ack_i[i] |=> flags_o[i]); // R9
    end
endmodule

// File: rtl/tifc_irq_gate.sv
module tifc_irq_gate
    import tifc_pkg::*;
(
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            gie_i,
    output logic [NSRC-1:0] irq_o
);
    always_comb begin
        irq_o = flags_i & en_i & {NSRC{gie_i}};
    end
endmodule

// File: rtl/tifc_top.sv
module tifc_top
    import tifc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    input  logic [CNT_W-1:0] cap_top,
    input  logic             top_is_cap,
    input  logic             ovf_evt,
    input  logic             cap_evt,
    input  logic [NCMP-1:0]  force_cmp,
    input  logic             gie,
    input  logic [NSRC-1:0]  ack,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic [NSRC-1:0]  irq
);
    logic [NCMP-1:0][CNT_W-1:0] cmp_vec;
    logic [NSRC-1:0] set_evt, clr_wr, en_wdata, flags, en;
    logic            en_wr;

    assign cmp_vec = {cmp_c, cmp_b, cmp_a};
    assign en_wr   = bus_wr & bus_addr;

    for (genvar i = 0; i < NSRC; i++) begin : g_map
        assign clr_wr[i]   = bus_wr & ~bus_addr & bus_wdata[src_bit(i)];
        assign en_wdata[i] = bus_wdata[src_bit(i)];
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NSRC; i++)
            bus_rdata[src_bit(i)] = bus_addr ? en[i] : flags[i];
    end

    tifc_event_gen #(.CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .count_i(count),
        .cmp_i(cmp_vec), .cap_top_i(cap_top), .top_is_cap_i(top_is_cap),
        .ovf_i(ovf_evt), .cap_i(cap_evt), .set_o(set_evt)
    );

    tifc_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(set_evt), .clr_i(clr_wr),
        .ack_i(ack), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
        .flags_o(flags), .en_o(en)
    );

    tifc_irq_gate u_gate (
        .flags_i(flags), .en_i(en), .gie_i(gie), .irq_o(irq)
    );

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> irq == '0); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~REG_MASK) == '0); // R2

    for (genvar c = 0; c < NCMP; c++) begin : g_force_chk
        AST_FORCE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            force_cmp[c] && !tick && !flags[SRC_CMPA+c] |=> !flags[SRC_CMPA+c]); // R6
    end
endmodule

// File: tb/test_tifc_top.sv
module test_tifc_top;
    localparam int CW = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          tick = 0, top_is_cap = 0, ovf_evt = 0, cap_evt = 0, gie = 0;
    logic [CW-1:0] count = 0, cmp_a = 0, cmp_b = 0, cmp_c = 0, cap_top = 0;
    logic [2:0]    force_cmp = 0;
    logic [4:0]    ack = 0;
    logic          bus_addr = 0, bus_wr = 0;
    logic [7:0]    bus_wdata = 0;
    logic [7:0]    bus_rdata;
    logic [4:0]    irq;

    tifc_top #(.CNT_W(CW)) i_tifc_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cap_top(cap_top),
        .top_is_cap(top_is_cap), .ovf_evt(ovf_evt), .cap_evt(cap_evt),
        .force_cmp(force_cmp), .gie(gie), .ack(ack), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    string req = "R1";
    int bp[5] = '{0, 1, 2, 3, 5};

    // behavioural reference state
    logic [7:0] mflag = 0, men = 0;
    logic [2:0] mpend = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired (%s) actual=running expected=finished", req);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic model_edge();
        logic [7:0] set_v, clr_v;
        logic [CW-1:0] cv[3];
        cv[0] = cmp_a; cv[1] = cmp_b; cv[2] = cmp_c;
        set_v = 0; clr_v = 0;
        if (!rst_n) begin
            mflag = 0; men = 0; mpend = 0;
            return;
        end
        if (tick) begin
            for (int c = 0; c < 3; c++) begin
                if (mpend[c]) set_v[c+1] = 1'b1;
                mpend[c] = (count == cv[c]);
            end
            if (ovf_evt) set_v[0] = 1'b1;
            if (top_is_cap && count == cap_top) set_v[5] = 1'b1;
        end
        if (cap_evt) set_v[5] = 1'b1;
        if (bus_wr && !bus_addr) clr_v = bus_wdata;
        for (int i = 0; i < 5; i++) if (ack[i]) clr_v[bp[i]] = 1'b1;
        mflag = ((mflag & ~clr_v) | set_v) & 8'h2F;
        if (bus_wr && bus_addr) men = bus_wdata & 8'h2F;
    endtask

    task automatic compare();
        logic [7:0] er;
        logic [4:0] ei;
        er = bus_addr ? men : mflag;
        for (int i = 0; i < 5; i++) ei[i] = mflag[bp[i]] & men[bp[i]] & gie;
        checks++;
        if (bus_rdata !== er || irq !== ei) begin
            errors++;
            $display("FAIL %s rdata=%h expected=%h irq=%b expected=%b", req, bus_rdata, er, irq, ei);
        end
    endtask

    // one clock: model follows the edge, outputs checked at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        tick = 0; ovf_evt = 0; cap_evt = 0; force_cmp = 0; ack = 0; bus_wr = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0;
    endtask

    initial begin
        cmp_a = 4'd9; cmp_b = 4'd9; cmp_c = 4'd9; cap_top = 4'd9; count = 4'd0;
        repeat (3) step();
        rst_n = 1;
        // R1 reset state on both registers
        req = "R1"; bus_addr = 0; step(); bus_addr = 1; step();
        // R3 enable register read/write, reserved bits dropped
        req = "R3"; wr(1, 8'hFF); step(); wr(1, 8'h0A); step(); wr(1, 8'h2F); step();
        // R2 reserved flag bits ignore writes
        req = "R2"; bus_addr = 0; wr(0, 8'hD0); step();
        // R7 overflow only with tick
        req = "R7"; ovf_evt = 1; tick = 0; step(); step(); tick = 1; step(); idle(); step();
        // R4 gie gating of a pending flag
        req = "R4"; gie = 0; step(); gie = 1; step(); bus_addr = 1; wr(1, 8'h00); step();
        bus_addr = 0; step(); wr(1, 8'h2F); gie = 1; bus_addr = 0; step();
        wr(0, 8'h2F); step();
        // R5 compare flag one tick after match, nothing between
        req = "R5"; cmp_a = 4'd3; count = 4'd3; tick = 1; step();
        tick = 0; count = 4'd0; step(); step(); step();
        tick = 1; step(); tick = 0; step();
        cmp_b = 4'd7; cmp_c = 4'd7; count = 4'd7; tick = 1; step(); count = 4'd8; step(); step();
        idle(); wr(0, 8'h0E); step();
        // R6 forced strobes never set
        req = "R6"; cmp_a = 4'd12; cmp_b = 4'd12; cmp_c = 4'd12; count = 4'd1;
        force_cmp = 3'b111; step(); tick = 1; step(); step(); force_cmp = 3'b010; step(); idle(); step();
        // R8 capture event and TOP hit
        req = "R8"; cap_evt = 1; step(); idle(); wr(0, 8'h20); step();
        top_is_cap = 1; cap_top = 4'd5; count = 4'd5; tick = 0; step();
        tick = 1; step(); idle(); wr(0, 8'h20);
        top_is_cap = 0; tick = 1; step(); idle(); step();
        // R9 write one clears, zero keeps
        req = "R9"; cap_evt = 1; ovf_evt = 1; tick = 1; step(); idle(); step();
        wr(0, 8'h00); step(); wr(0, 8'h01); step(); wr(0, 8'h20); step();
        // R10 ack per vector
        req = "R10"; ovf_evt = 1; cap_evt = 1; tick = 1; step(); idle();
        ack = 5'b10000; step(); ack = 5'b00001; step(); ack = 0; step();
        // R11 set wins over write and ack
        req = "R11"; ovf_evt = 1; tick = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h01; step();
        idle(); step(); cap_evt = 1; ack = 5'b10000; step(); idle(); step();
        // mixed random traffic
        req = "R4 R5 R7 R8 R9 R10 R11 random";
        for (int n = 0; n < 4000; n++) begin
            tick = ($urandom % 3) != 0;
            count = CW'($urandom); cmp_a = CW'($urandom % 4); cmp_b = CW'($urandom % 4);
            cmp_c = CW'($urandom % 4); cap_top = CW'($urandom % 4);
            top_is_cap = $urandom % 2; ovf_evt = ($urandom % 4) == 0;
            cap_evt = ($urandom % 6) == 0; force_cmp = 3'($urandom);
            gie = ($urandom % 4) != 0;
            ack = (($urandom % 3) == 0) ? (5'b1 << ($urandom % 5)) : 5'b0;
            bus_addr = $urandom % 2; bus_wr = ($urandom % 5) == 0; bus_wdata = 8'($urandom);
            step();
        end
        idle(); step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule